// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one read or write burst in a synchronous DRAM controller or device model. When a column command is accepted, it captures the starting column, the burst length code and the wrap order. From the following clock on, it issues one column per cycle. Each column stays inside the aligned block that the burst length defines. A sequential burst counts upward and wraps within that block. An interleaved burst XORs the beat count into the low bits of the start column.

A full-page burst walks through every column of the row, wraps from the top column to column 0, and runs until it is stopped. A burst ends after its last beat, or one clock after a terminate request. A new command may replace a burst in progress on any cycle. The replacement takes effect on the very next beat, so column commands may be issued back to back every clock.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and after its release, `valid_o`, `last_o` and `err_o` are 0 and `col_o` is 0.
- R2: When `start_i` is sampled high at a clock edge, the outputs from that edge on show `valid_o`=1 and `col_o`=`start_col_i`. Each further edge advances the burst by one beat.
- R3: `blen_i` encodes the length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. The codes 3'b100, 3'b101 and 3'b110 act as 1 beat. A fixed-length burst shows exactly that many valid beats, and then `valid_o` returns to 0.
- R4: With `order_i`=0 (sequential), beat k of an N-beat burst keeps the column bits above log2(N) from the start column. Its low log2(N) bits equal (start + k) mod N.
- R5: With `order_i`=1 (interleaved), beat k keeps the same upper bits. Its low log2(N) bits equal the low bits of the start column XOR k.
- R6: In full-page mode, beat k shows (start + k) mod 2^COL_W. The column wraps from the top column to 0, and the burst never ends by itself.
- R7: Full page requested with `order_i`=1 runs as a sequential full page and sets `err_o`=1. Every start captures `err_o` anew, so any other start clears it.
- R8: `last_o` is 1 exactly on the final beat of a fixed-length burst. It is never 1 in full-page mode or while `valid_o` is 0.
- R9: If `term_i` is high in a cycle where `valid_o` is 1, the beat shown in that cycle is the last one: `valid_o` is 0 after the next edge. `term_i` has no effect when no burst is active.
- R10: `start_i` during an active burst restarts the sequence at the next edge, from the new start column with the new length and order. If `start_i` and `term_i` are high together, the start wins.
- R11: `start_i` held high on consecutive cycles yields each command's start column on consecutive beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Column command accepted; loads a new burst |
| start_col_i | input | COL_W | Starting column of the new burst |
| blen_i | input | 3 | Burst length code |
| order_i | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| term_i | input | 1 | Stop the current burst after the present beat |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | A burst beat is present on `col_o` |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Last start asked for an interleaved full page |

## Verification
The bench uses the default COL_W of 9, the real column width. With this value, a full-page burst crosses the wrap from column 511 to 0 within a few hundred cycles. It also makes start columns with nonzero upper bits show that sequential and interleaved bursts stay inside their aligned block. Lengths 1 through 8 in both orders, the reserved codes, termination in the middle of a burst and while idle, interruption and back-to-back starts are all compared beat by beat against a behavioural model.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int unsigned LEN_CODE_W = 3;
    localparam logic [LEN_CODE_W-1:0] LEN_FULL_PAGE = 3'b111;
    localparam int unsigned MAX_FIXED_CODE = 3;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [LEN_CODE_W-1:0] code_i,
    input  logic                  ilv_req_i,
    output logic [COL_W-1:0]      mask_o,
    output logic                  full_o,
    output logic                  ilv_o,
    output logic                  err_o
);

    logic fixed_ok;

    assign full_o   = (code_i == LEN_FULL_PAGE);
    assign fixed_ok = (int'(code_i) <= int'(MAX_FIXED_CODE));

    // Low-bit mask: all ones for full page, (2^code)-1 for fixed codes,
    // zero (single beat) for the reserved codes.
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask_o[i] = full_o | (fixed_ok && (int'(code_i) > i));
    end

    // Interleaving is not defined across a whole page: fall back to sequential.
    assign ilv_o = ilv_req_i & ~full_o;
    assign err_o = ilv_req_i &  full_o;

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    assign low_seq = base_i + beat_i;
    assign low_ilv = base_i ^ beat_i;

    // Bits outside the mask come from the start column; bits inside from the
    // selected ordering.
    assign col_o = (base_i & ~mask_i) | ((ilv_i ? low_ilv : low_seq) & mask_i);

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] blen_i,
    input  logic                  order_i,
    input  logic                  term_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  valid_o,
    output logic                  last_o,
    output logic                  err_o
);

    typedef struct packed {
        logic             valid;
        logic             last;
        logic             err;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] beat;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_ilv;
    logic             dec_err;
    logic [COL_W-1:0] beat_nxt;
    logic [COL_W-1:0] gen_col;

    bcs_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i    (blen_i),
        .ilv_req_i (order_i == ORD_ILV),
        .mask_o    (dec_mask),
        .full_o    (dec_full),
        .ilv_o     (dec_ilv),
        .err_o     (dec_err)
    );

    assign beat_nxt = state_q.beat + 1'b1;

    bcs_addr_gen #(.COL_W(COL_W)) u_gen (
        .base_i (state_q.base),
        .beat_i (beat_nxt),
        .mask_i (state_q.mask),
        .ilv_i  (state_q.ilv),
        .col_o  (gen_col)
    );

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d.valid = 1'b1;
            state_d.base  = start_col_i;
            state_d.mask  = dec_mask;
            state_d.full  = dec_full;
            state_d.ilv   = dec_ilv;
            state_d.err   = dec_err;
            state_d.beat  = '0;
            state_d.col   = start_col_i;
            state_d.last  = ~dec_full && (dec_mask == '0);
        end else if (state_q.valid && (term_i || state_q.last)) begin
            state_d.valid = 1'b0;
            state_d.last  = 1'b0;
        end else if (state_q.valid) begin
            state_d.beat  = beat_nxt;
            state_d.col   = gen_col;
            state_d.last  = ~state_q.full && (beat_nxt == state_q.mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign col_o   = state_q.col;
    assign valid_o = state_q.valid;
    assign last_o  = state_q.last;
    assign err_o   = state_q.err;

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));            // R2
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && last_o && !start_i) |=> !valid_o);                    // R3
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((col_o & ~state_q.mask) == (state_q.base & ~state_q.mask))); // R4
    AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && state_q.full) |-> !last_o);                           // R6
    AST_ERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (err_o == ($past(blen_i) == LEN_FULL_PAGE && $past(order_i)))); // R7
    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);                                              // R8
    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && term_i && !start_i) |=> !valid_o);                    // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> (!valid_o && $stable(col_o)));         // R9

endmodule

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;

    localparam int COL_W = 9;
    localparam int NCOL  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       blen_i = '0;
    logic             order_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_act = 0, m_k = 0, m_s = 0, m_n = 1, m_il = 0, m_err = 0, m_col = 0;

    always #2 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .order_i(order_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    function automatic int beats_of(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int s, input int k, input int n, input int il);
        int base, off;
        if (n == 0) return (s + k) % NCOL;
        base = s - (s % n);
        off  = s % n;
        if (il != 0) return base + (off ^ k);
        return base + ((off + k) % n);
    endfunction

    task automatic compare(input string tag);
        int e_last;
        e_last = (m_act != 0 && m_n != 0 && m_k == m_n - 1) ? 1 : 0;
        checks++;
        if (int'(valid_o) != m_act || int'(last_o) != e_last ||
            int'(err_o) != m_err || int'(col_o) != m_col) begin
            errors++;
            $display("FAIL %s: valid/last/err/col actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     tag, valid_o, last_o, err_o, col_o, m_act, e_last, m_err, m_col);
        end
    endtask

    task automatic step(input bit s, input int c, input int l, input bit t,
                        input bit tr, input string tag);
        start_i = s; start_col_i = COL_W'(c); blen_i = 3'(l); order_i = t; term_i = tr;
        @(posedge clk);
        if (s) begin
            m_act = 1; m_k = 0; m_s = c; m_n = beats_of(l);
            m_il = (t && m_n != 0) ? 1 : 0;
            m_err = (l == 7 && t) ? 1 : 0;
            m_col = c;
        end else if (m_act != 0 && (tr || (m_n != 0 && m_k == m_n - 1))) begin
            m_act = 0;
        end else if (m_act != 0) begin
            m_k++;
            m_col = exp_col(m_s, m_k, m_n, m_il);
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
    endtask

    task automatic burst(input int c, input int l, input bit t, input string tag);
        step(1, c, l, t, 0, tag);
        for (int i = 0; i < 12 && m_act != 0; i++) step(0, 0, 0, 0, 0, tag);
        idle(1, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset held");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        // R2 R3 R4 R8: sequential, every fixed length, aligned and unaligned
        for (int l = 0; l < 4; l++) begin
            burst(9'h0A8, l, 0, "R3 R4 R8 seq");
            burst(9'h157, l, 0, "R2 R4 R8 seq");
        end
        // R5: interleaved, every fixed length
        for (int l = 0; l < 4; l++) begin
            burst(9'h0A5, l, 1, "R5 ilv");
            burst(9'h1F3, l, 1, "R5 R8 ilv");
        end
        // R3: reserved codes behave as one beat
        for (int l = 4; l < 7; l++) burst(9'h033, l, 1, "R3 reserved code");

        // R6: full page across the wrap, then R9 terminate
        step(1, 500, 7, 0, 0, "R6 full start");
        idle(520, "R6 full run");
        step(0, 0, 0, 0, 1, "R9 term full");
        idle(2, "R9 after term");

        // R7: interleaved full page runs sequentially and flags error
        step(1, 509, 7, 1, 0, "R7 ilv full");
        idle(6, "R7 ilv full run");
        step(0, 0, 0, 0, 1, "R7 term");
        idle(1, "R7 err held");
        burst(9'h010, 2, 0, "R7 err cleared");

        // R9: terminate mid-burst and while idle
        step(1, 9'h041, 3, 0, 0, "R9 start");
        idle(2, "R9 mid");
        step(0, 0, 0, 0, 1, "R9 term mid");
        idle(2, "R9 stopped");
        step(0, 0, 0, 0, 1, "R9 term idle");
        idle(1, "R9 idle");

        // R10: interrupt, and start beating terminate
        step(1, 9'h100, 3, 0, 0, "R10 first");
        idle(3, "R10 first run");
        step(1, 9'h0E6, 2, 1, 0, "R10 interrupt");
        idle(1, "R10 second run");
        step(1, 9'h07D, 7, 0, 1, "R10 start wins term");
        idle(3, "R10 full run");
        step(1, 9'h005, 1, 0, 0, "R10 shorten");
        idle(3, "R10 shorten run");

        // R11: back-to-back starts
        for (int i = 0; i < 6; i++) step(1, 37 * i + 3, i % 4, i[0], 0, "R11 back to back");
        idle(10, "R11 tail");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule